// File: doc/BRIEF.md
# Serial EEPROM Transfer Sequencer

This block turns a host request ("move N bytes to or from EEPROM address A") into the command-level traffic a serial EEPROM with a 16-bit address expects. It sits on top of a byte-wide SPI master. The master shifts one byte per handshake and returns the byte it clocked in. The sequencer drives the chip-select level, hands over one byte at a time and waits for the acknowledge before it sends the next.

Requests are cut into pieces of at most 16 data bytes, and the address moves forward by the size of each piece. For a write piece, the sequencer first unlocks the device with a one-byte enable transaction. It then sends the write command with address and data. After that it reads the status register repeatedly, with a programmable idle time between reads, until the device reports that it is no longer busy, or until 1000 reads have all come back busy. For a read piece, it sends the read command and address, then clocks out filler bytes and streams back what the device returns. The host sees a one-cycle start, a level `busy`, a one-cycle `done` after the whole request, and a sticky timeout flag.

Top module: `spi_eeprom_seq`

## Requirements
- R1: The first byte of every chip-select window is a command code: 0x06 for enable-write, 0x05 for status read, 0x03 for read and 0x02 for write.
- R2: In read and write windows, the command is followed directly by the 16-bit address, upper byte first.
- R3: A request of L bytes becomes ceil(L/16) data windows. Each window carries at most 16 data bytes, and each one starts at the previous address plus the previous window's byte count, with the address wrapping at 16 bits.
- R4: Every write window is preceded by its own window holding only 0x06. `spi_sel` goes low for at least one cycle after the last byte of every window.
- R5: After each write window, status windows of two bytes (0x05, 0x00) repeat until bit 0 of the second received byte is 0. Consecutive status windows are separated by more than `poll_gap` cycles.
- R6: If 1000 status reads in a row show bit 0 set, the request ends with `timed_out` set and a `done` pulse. `timed_out` stays set until the next accepted start.
- R7: A read window holds the command, the address and one 0x00 filler byte per data byte, all under one chip select. The bytes received after the three header bytes appear in order on `rd_data`, each with a one-cycle `rd_valid`.
- R8: Each write data byte is sent in the cycle `wr_take` is high, taken from `wr_data`. Bytes are sent in stream order and land at consecutive addresses.
- R9: A start with length 0 produces `done` in the next cycle, with no chip-select activity and `busy` staying low.
- R10: `done` is a single-cycle pulse after the last window and is never high together with `busy`. `busy` is high while a nonzero request runs. `spi_go` occurs only with `spi_sel` high and never in two cycles in a row.
- R11: After reset, `busy`, `done`, `timed_out`, `spi_sel` and `spi_go` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | One-cycle request strobe, accepted when idle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 16 | First EEPROM address |
| req_len | input | LEN_W | Number of data bytes |
| poll_gap | input | GAP_W | Idle cycles between status reads |
| wr_data | input | 8 | Next write data byte from the host |
| wr_take | output | 1 | Current `wr_data` is consumed this cycle |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished (pulse) |
| timed_out | output | 1 | Last request gave up on status polling |
| spi_sel | output | 1 | Chip-select level (1 = device selected) |
| spi_go | output | 1 | Send `spi_tx` now |
| spi_tx | output | 8 | Byte to shift out |
| spi_ack | input | 1 | Byte exchange finished |
| spi_rx | input | 8 | Byte shifted in, valid with `spi_ack` |

## Verification
The bound checker watches, on every cycle, the properties that are local in time. These are: a command code at each chip-select rise, chip select dropping after each window's last byte, one byte in flight at a time, data hand-off only with a send, the shape of `done`, the hold of `timed_out`, and no selection while idle. Other properties only show up once the whole SPI stream is seen. These are the chunk count and sizes, the address sequence, the enable-before-write ordering, the number of status reads and their spacing, and the data round trip. They need the bench's EEPROM model, which decodes every window and compares memory and read-back against the bench's own reckoning.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  // command byte plus two address bytes
  localparam int unsigned HDR_BYTES = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREN,
    ST_BODY,
    ST_POLL,
    ST_WAIT
  } seq_state_t;

  function automatic int unsigned chunk_of(int unsigned remain, int unsigned lim);
    return (remain > lim) ? lim : remain;
  endfunction

  // index of the final byte inside the current chip-select window
  function automatic int unsigned last_index(seq_state_t st, int unsigned chunk);
    case (st)
      ST_BODY: return HDR_BYTES + chunk - 1;
      ST_POLL: return 1;
      default: return 0;
    endcase
  endfunction

  // byte to put on the wire at position idx of the current window
  function automatic logic [7:0] frame_byte(seq_state_t st, logic is_wr, int unsigned idx,
                                            logic [15:0] addr, logic [7:0] wdata);
    case (st)
      ST_WREN: return OP_WREN;
      ST_POLL: return (idx == 0) ? OP_RDSR : 8'h00;
      ST_BODY: begin
        case (idx)
          0:       return is_wr ? OP_WRITE : OP_READ;
          1:       return addr[15:8];
          2:       return addr[7:0];
          default: return is_wr ? wdata : 8'h00;
        endcase
      end
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/spi_eeprom_chunker.sv
module spi_eeprom_chunker
  import spi_eeprom_pkg::*;
#(
  parameter int unsigned LEN_W = 12,
  parameter int unsigned CHUNK = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [15:0]                  load_addr,
  input  logic [LEN_W-1:0]             load_len,
  input  logic                         advance,
  output logic [15:0]                  cur_addr,
  output logic [$clog2(CHUNK+1)-1:0]   chunk,
  output logic                         last_chunk
);
  localparam int unsigned CW = $clog2(CHUNK + 1);

  logic [LEN_W-1:0] remain;

  always_comb begin
    chunk      = CW'(chunk_of(32'(remain), CHUNK));
    last_chunk = (32'(remain) <= CHUNK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      cur_addr <= load_addr;
      remain   <= load_len;
    end else if (advance) begin
      cur_addr <= cur_addr + 16'(chunk);
      remain   <= remain - LEN_W'(chunk);
    end
  end
endmodule

// File: rtl/spi_eeprom_poll.sv
module spi_eeprom_poll #(
  parameter int unsigned MAX_POLLS = 1000,
  parameter int unsigned GAP_W     = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             busy_seen,
  input  logic [GAP_W-1:0] gap,
  output logic             wait_over,
  output logic             last_try
);
  localparam int unsigned TW = $clog2(MAX_POLLS + 1);

  logic [TW-1:0]    tries;
  logic [GAP_W-1:0] cnt;

  always_comb begin
    last_try  = (32'(tries) == MAX_POLLS - 1);
    wait_over = (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tries <= '0;
      cnt   <= '0;
    end else begin
      if (clear)          tries <= '0;
      else if (busy_seen) tries <= tries + TW'(1);
      if (busy_seen)      cnt   <= gap;
      else if (cnt != '0) cnt   <= cnt - GAP_W'(1);
    end
  end
endmodule

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq #(
  parameter int unsigned LEN_W     = 12,
  parameter int unsigned CHUNK     = 16,
  parameter int unsigned MAX_POLLS = 1000,
  parameter int unsigned GAP_W     = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic             req_write,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [GAP_W-1:0] poll_gap,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             timed_out,
  output logic             spi_sel,
  output logic             spi_go,
  output logic [7:0]       spi_tx,
  input  logic             spi_ack,
  input  logic [7:0]       spi_rx
);
  import spi_eeprom_pkg::*;

  localparam int unsigned CW    = $clog2(CHUNK + 1);
  localparam int unsigned IDX_W = $clog2(CHUNK + HDR_BYTES + 1);

  seq_state_t       state;
  logic             is_wr, cs_q, pend;
  logic [IDX_W-1:0] bidx;
  logic [15:0]      cur_addr;
  logic [CW-1:0]    chunk;
  logic             last_chunk, wait_over, last_try;

  // named events
  logic in_txn, byte_fin, txn_end, data_phase;
  logic chunk_end, poll_busy, poll_clear, finish, accept, load;

  always_comb begin
    in_txn     = (state == ST_WREN) || (state == ST_BODY) || (state == ST_POLL);
    spi_go     = in_txn && cs_q && !pend;
    byte_fin   = pend && spi_ack;
    txn_end    = byte_fin && (32'(bidx) == last_index(state, 32'(chunk)));
    data_phase = (state == ST_BODY) && (32'(bidx) >= HDR_BYTES);
    spi_tx     = frame_byte(state, is_wr, 32'(bidx), cur_addr, wr_data);
    wr_take    = spi_go && data_phase && is_wr;
    chunk_end  = txn_end && (((state == ST_BODY) && !is_wr) ||
                             ((state == ST_POLL) && !spi_rx[0]));
    poll_busy  = txn_end && (state == ST_POLL) && spi_rx[0];
    poll_clear = txn_end && (state == ST_BODY) && is_wr;
    finish     = (chunk_end && last_chunk) || (poll_busy && last_try);
    accept     = (state == ST_IDLE) && req_start;
    load       = accept && (req_len != '0);
    busy       = (state != ST_IDLE);
    spi_sel    = cs_q;
  end

  spi_eeprom_chunker #(.LEN_W(LEN_W), .CHUNK(CHUNK)) u_chunker (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_addr  (req_addr),
    .load_len   (req_len),
    .advance    (chunk_end),
    .cur_addr   (cur_addr),
    .chunk      (chunk),
    .last_chunk (last_chunk)
  );

  spi_eeprom_poll #(.MAX_POLLS(MAX_POLLS), .GAP_W(GAP_W)) u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (poll_clear),
    .busy_seen (poll_busy),
    .gap       (poll_gap),
    .wait_over (wait_over),
    .last_try  (last_try)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      is_wr     <= 1'b0;
      cs_q      <= 1'b0;
      pend      <= 1'b0;
      bidx      <= '0;
      done      <= 1'b0;
      timed_out <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      if (spi_go) pend <= 1'b1;
      if (byte_fin) begin
        pend <= 1'b0;
        bidx <= txn_end ? '0 : bidx + IDX_W'(1);
      end
      if (txn_end)                        cs_q <= 1'b0;
      else if (in_txn && !cs_q && !pend)  cs_q <= 1'b1;
      if (byte_fin && data_phase && !is_wr) begin
        rd_valid <= 1'b1;
        rd_data  <= spi_rx;
      end
      if (poll_busy && last_try) timed_out <= 1'b1;
      if (finish)                done      <= 1'b1;
      case (state)
        ST_IDLE: if (accept) begin
          timed_out <= 1'b0;
          is_wr     <= req_write;
          if (req_len == '0) done  <= 1'b1;
          else               state <= req_write ? ST_WREN : ST_BODY;
        end
        ST_WREN: if (txn_end) state <= ST_BODY;
        ST_BODY: if (txn_end) begin
          if (is_wr)           state <= ST_POLL;
          else if (last_chunk) state <= ST_IDLE;
        end
        ST_POLL: if (txn_end) begin
          if (!spi_rx[0]) state <= last_chunk ? ST_IDLE : ST_WREN;
          else            state <= last_try ? ST_IDLE : ST_WAIT;
        end
        ST_WAIT: if (wait_over) state <= ST_POLL;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_eeprom_seq_chk.sv
module spi_eeprom_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_start,
  input logic       busy,
  input logic       done,
  input logic       timed_out,
  input logic       spi_sel,
  input logic       spi_go,
  input logic [7:0] spi_tx,
  input logic       wr_take,
  input logic       txn_end
);
  AST_OPCODE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sel) |-> spi_go && (spi_tx == 8'h06 || spi_tx == 8'h05 ||
                                  spi_tx == 8'h03 || spi_tx == 8'h02)); // R1
  AST_SEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    txn_end |=> !spi_sel); // R4
  AST_GO_IN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    spi_go |-> spi_sel); // R10
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    spi_go |=> !spi_go); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_TIMEOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (timed_out && !req_start) |=> timed_out); // R6
  AST_TAKE_ON_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> spi_go); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sel); // R9
endmodule

bind spi_eeprom_seq spi_eeprom_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_start (req_start),
  .busy      (busy),
  .done      (done),
  .timed_out (timed_out),
  .spi_sel   (spi_sel),
  .spi_go    (spi_go),
  .spi_tx    (spi_tx),
  .wr_take   (wr_take),
  .txn_end   (txn_end)
);

// File: tb/spi_eeprom_seq_tb.sv
module spi_eeprom_seq_tb;
  localparam int LEN_W    = 12;
  localparam int GAP_W    = 20;
  localparam int WD_LIMIT = 150000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_start = 1'b0, req_write = 1'b0;
  logic [15:0]      req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [GAP_W-1:0] poll_gap = '0;
  logic [7:0]       wr_data;
  logic             wr_take, rd_valid, busy, done, timed_out, spi_sel, spi_go;
  logic [7:0]       rd_data, spi_tx;
  logic             spi_ack = 1'b0;
  logic [7:0]       spi_rx = '0;

  always #5 clk = ~clk;

  spi_eeprom_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .poll_gap(poll_gap),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .done(done), .timed_out(timed_out), .spi_sel(spi_sel),
    .spi_go(spi_go), .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx)
  );

  int n_checks = 0, n_err = 0, cyc = 0;
  logic [7:0] wbuf [0:255];
  logic [7:0] rbuf [0:255];
  logic [7:0] mem  [0:1023];
  int widx, ridx;
  assign wr_data = wbuf[widx[7:0]];

  // EEPROM model state and per-request statistics
  logic        sel_prev = 1'b0, ack_pend = 1'b0, wel = 1'b0;
  logic [7:0]  rx_hold, op;
  logic [15:0] a_cur, exp_addr;
  int pos, data_cnt, wip_left, busy_polls;
  int n_wren, n_wtxn, n_rtxn, n_rdsr, n_sel_rise, n_done, max_chunk;
  int no_wel, addr_err, bad_wren, last_rdsr, min_gap;
  bit saw_busy;

  function automatic int exp_chunks(int len);
    return (len + 15) / 16;
  endfunction

  function automatic int mem_idx(logic [15:0] a, int off);
    logic [15:0] s;
    s = a + 16'(off);
    return int'(s[9:0]);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic close_window();
    if (op == 8'h06 && pos != 1) bad_wren++;
    if (op == 8'h02 || op == 8'h03) begin
      if (data_cnt > max_chunk) max_chunk = data_cnt;
      exp_addr = exp_addr + 16'(data_cnt);
      if (op == 8'h02) begin n_wtxn++; wel = 1'b0; wip_left = busy_polls; end
      else n_rtxn++;
    end
    data_cnt = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
    if (ack_pend) begin spi_ack = 1'b1; spi_rx = rx_hold; ack_pend = 1'b0; end
    else spi_ack = 1'b0;
    if (spi_sel && !sel_prev) begin pos = 0; n_sel_rise++; end
    if (!spi_sel && sel_prev) close_window();
    sel_prev = spi_sel;
    if (spi_go) begin
      rx_hold = 8'h00;
      if (pos == 0) begin
        op = spi_tx;
        if (op == 8'h06) begin wel = 1'b1; n_wren++; end
        if (op == 8'h05) begin
          n_rdsr++;
          if (last_rdsr >= 0 && cyc - last_rdsr < min_gap) min_gap = cyc - last_rdsr;
          last_rdsr = cyc;
        end
      end else if (op == 8'h02 || op == 8'h03) begin
        if (pos == 1) a_cur[15:8] = spi_tx;
        else if (pos == 2) begin
          a_cur[7:0] = spi_tx;
          if (a_cur != exp_addr) addr_err++;
        end else begin
          data_cnt++;
          if (op == 8'h02) begin
            if (!wel) no_wel++;
            mem[mem_idx(a_cur, pos - 3)] = spi_tx;
          end else rx_hold = mem[mem_idx(a_cur, pos - 3)];
        end
      end else if (op == 8'h05 && pos == 1) begin
        rx_hold = {7'b0, (wip_left > 0)};
        if (wip_left > 0) wip_left--;
      end
      pos++;
      ack_pend = 1'b1;
    end
    if (wr_take) widx++;
    if (rd_valid) begin rbuf[ridx[7:0]] = rd_data; ridx++; end
    if (done) n_done++;
    if (busy) saw_busy = 1'b1;
  end

  int wait_cyc;

  task automatic run_req(input bit wr, input logic [15:0] a, input int len,
                         input int bp, input int gap);
    @(negedge clk);
    busy_polls = bp; wip_left = 0; exp_addr = a;
    widx = 0; ridx = 0; n_wren = 0; n_wtxn = 0; n_rtxn = 0; n_rdsr = 0;
    n_sel_rise = 0; n_done = 0; max_chunk = 0; no_wel = 0; addr_err = 0;
    bad_wren = 0; last_rdsr = -1; min_gap = 1000000; saw_busy = 1'b0;
    req_write = wr; req_addr = a; req_len = LEN_W'(len); poll_gap = GAP_W'(gap);
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    wait_cyc = 0;
    while (n_done == 0) begin @(negedge clk); wait_cyc++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic write_then_read(input logic [15:0] a, input int len, input int bp,
                                 input int gap);
    int ch, bad;
    ch = exp_chunks(len);
    for (int i = 0; i < len; i++) wbuf[i] = 8'($urandom);
    run_req(1'b1, a, len, bp, gap);
    check(n_wtxn == ch, "R3 write window count", n_wtxn, ch);
    check(max_chunk <= 16, "R3 window size", max_chunk, 16);
    check(addr_err == 0, "R2 R3 address sequence", addr_err, 0);
    check(n_wren == ch && no_wel == 0 && bad_wren == 0, "R4 enable before write",
          n_wren, ch);
    check(n_rdsr == ch * (bp + 1), "R5 status read count", n_rdsr, ch * (bp + 1));
    if (bp > 0) check(min_gap > gap, "R5 status spacing", min_gap, gap + 1);
    check(widx == len, "R8 bytes taken", widx, len);
    bad = 0;
    for (int i = 0; i < len; i++) if (mem[mem_idx(a, i)] != wbuf[i]) bad++;
    check(bad == 0, "R8 written data order", bad, 0);
    check(n_done == 1 && saw_busy && !timed_out, "R10 write completion", n_done, 1);
    run_req(1'b0, a, len, 0, gap);
    check(n_rtxn == ch && n_wren == 0 && n_rdsr == 0, "R7 read windows", n_rtxn, ch);
    check(addr_err == 0, "R2 read address", addr_err, 0);
    bad = 0;
    for (int i = 0; i < len; i++) if (rbuf[i] != wbuf[i]) bad++;
    check(ridx == len && bad == 0, "R7 read data", bad, 0);
    check(n_done == 1, "R10 read completion", n_done, 1);
  endtask

  initial begin
    void'($urandom(32'd7719));
    for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
    for (int i = 0; i < 256; i++) wbuf[i] = 8'h00;
    widx = 0; ridx = 0; busy_polls = 0; wip_left = 0; op = 8'h00;
    repeat (3) @(negedge clk);
    check(!busy && !done && !timed_out && !spi_sel && !spi_go, "R11 reset state",
          {busy, done, timed_out, spi_sel, spi_go}, 0);
    rst_n = 1'b1;

    run_req(1'b1, 16'h0040, 0, 0, 0);
    check(n_done == 1 && wait_cyc <= 1, "R9 zero length done", wait_cyc, 0);
    check(n_sel_rise == 0 && !saw_busy, "R9 zero length quiet", n_sel_rise, 0);

    write_then_read(16'h0123, 17, 2, 3);
    write_then_read(16'hFFF8, 16, 0, 0);
    write_then_read(16'h0200, 1, 1, 6);
    for (int k = 0; k < 5; k++)
      write_then_read(16'($urandom), $urandom_range(1, 60), $urandom_range(0, 3),
                      $urandom_range(0, 5));

    run_req(1'b1, 16'h0300, 3, 5000, 0);
    check(timed_out == 1'b1, "R6 timeout flag", timed_out, 1);
    check(n_rdsr == 1000, "R6 status read limit", n_rdsr, 1000);
    check(n_done == 1, "R6 done on timeout", n_done, 1);
    repeat (20) @(negedge clk);
    check(timed_out == 1'b1, "R6 flag held", timed_out, 1);
    run_req(1'b0, 16'h0300, 0, 0, 0);
    check(timed_out == 1'b0, "R6 flag cleared by start", timed_out, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule